// File: doc/BRIEF.md
# Distributed Row Refresh Scheduler

This block decides when a dynamic memory array gets its next row refresh and which row that refresh covers. It counts clock cycles so that refreshes are spread evenly over the retention period. When a refresh is due, it raises a request towards the memory controller. The row to refresh comes from an internal row counter, so the controller never supplies a refresh address.

When the controller grants the request, the block stays busy for a fixed number of cycles while the row is refreshed. When that occupancy ends, the row counter steps to the next row. If the controller holds off while further intervals pass, the owed refreshes are counted up to a fixed ceiling and then served back to back once grants resume.

The spacing between refreshes is computed at elaboration time from the clock frequency, the retention period and the row count. With the defaults (133 MHz clock, 64 ms period, 8192 rows) the spacing is 1039 cycles. At 4 cycles per row, refresh takes about 0.4 % of the period.

Top module: `refresh_scheduler`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `ref_req` and `ref_busy` are 0 and `ref_row` is 0.
- R2: The refresh interval is INTERVAL = floor((CLK_KHZ * PERIOD_US / 1000) / ROWS) cycles (1039 by default). One refresh becomes owed every INTERVAL cycles. With grants given at once, `ref_req` is first seen high exactly INTERVAL rising edges after reset is released, and again on every following multiple of INTERVAL.
- R3: Once raised, `ref_req` stays high, and `ref_row` holds its value, on every cycle until a grant is seen.
- R4: A rising edge with `ref_req` and `ref_grant` both high accepts a refresh. On the next cycle `ref_req` is low and `ref_busy` is high, and `ref_busy` stays high for exactly BUSY_CYCLES cycles (4 by default).
- R5: `ref_row` holds during busy. It increases by one on the cycle after busy ends, so the accepted refreshes cover rows 0, 1, 2 … in order.
- R6: After the last row (ROWS-1) is refreshed, `ref_row` wraps to 0.
- R7: Intervals that elapse without a grant are each recorded as owed. `ref_req` is never high while `ref_busy` is high. It returns on the cycle after busy ends for as long as refreshes are still owed, so N owed refreshes are served back to back.
- R8: The owed count saturates at PEND_MAX (8 by default). After more than PEND_MAX intervals without a grant, exactly PEND_MAX refreshes are served.
- R9: `ref_grant` while `ref_req` is low is ignored: `ref_busy` stays low and `ref_row` is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_grant | input | 1 | Controller grants the pending refresh |
| ref_req | output | 1 | A refresh is owed and the block is idle |
| ref_row | output | ROW_W | Row that the next or current refresh covers |
| ref_busy | output | 1 | A granted row refresh is in progress |

## Verification
Timing of each result:
- The first request appears exactly INTERVAL edges after reset release. The bench keeps an edge counter from release and compares against multiples of INTERVAL at the sample where the request first shows.
- A grant takes effect on the edge that samples it. Request low and busy high are therefore checked at the very next half-period sample.
- The busy run is counted sample by sample and must equal BUSY_CYCLES when busy drops.
- The row increment is due on the sample right after busy falls. That is exactly where the next expected row from the scoreboard queue is compared when the following grant lands.
- Backlog and saturation windows are started on the sample just after a tick. No new interval can then add an extra owed refresh during the drain.

// File: rtl/refresh_pkg.sv
package refresh_pkg;

   typedef enum logic {
      SEQ_IDLE = 1'b0,
      SEQ_BUSY = 1'b1
   } seq_state_e;

   // Cycles between refreshes: whole period in cycles divided by row count.
   function automatic int unsigned refresh_interval(input int unsigned clk_khz,
                                                    input int unsigned period_us,
                                                    input int unsigned rows);
      longint unsigned total;
      total = (longint'(clk_khz) * longint'(period_us)) / 64'd1000;
      return int'(total / longint'(rows));
   endfunction

endpackage

// File: rtl/refresh_tick_gen.sv
module refresh_tick_gen #(
   parameter int unsigned INTERVAL = 1039
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int unsigned CW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
   localparam logic [CW-1:0] LAST = CW'(INTERVAL - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (cnt_q == LAST) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign tick = (cnt_q == LAST);

endmodule

// File: rtl/refresh_pend_ctr.sv
module refresh_pend_ctr #(
   parameter int unsigned PEND_MAX = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic take,
   output logic owed
);
   localparam int unsigned PW = $clog2(PEND_MAX + 1);
   localparam logic [PW-1:0] CAP = PW'(PEND_MAX);

   logic [PW-1:0] pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
      end else begin
         unique case ({tick, take})
            2'b10:   if (pend_q != CAP) pend_q <= pend_q + 1'b1;
            2'b01:   pend_q <= pend_q - 1'b1;
            default: pend_q <= pend_q;
         endcase
      end
   end

   assign owed = (pend_q != '0);

endmodule

// File: rtl/refresh_row_seq.sv
module refresh_row_seq
   import refresh_pkg::*;
#(
   parameter int unsigned ROWS        = 8192,
   parameter int unsigned BUSY_CYCLES = 4,
   localparam int unsigned ROW_W      = $clog2(ROWS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   output logic             busy,
   output logic [ROW_W-1:0] row
);
   localparam int unsigned BW = $clog2(BUSY_CYCLES + 1);
   localparam logic [BW-1:0] BLOAD = BW'(BUSY_CYCLES - 1);
   localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);

   seq_state_e       state_q;
   logic [BW-1:0]    bcnt_q;
   logic [ROW_W-1:0] row_q;
   logic [ROW_W-1:0] row_next;

   generate
      if ((ROWS & (ROWS - 1)) == 0) begin : g_row_pow2
         assign row_next = row_q + 1'b1;
      end else begin : g_row_cmp
         assign row_next = (row_q == ROW_LAST) ? '0 : row_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         bcnt_q  <= '0;
         row_q   <= '0;
      end else begin
         unique case (state_q)
            SEQ_IDLE: begin
               if (start) begin
                  state_q <= SEQ_BUSY;
                  bcnt_q  <= BLOAD;
               end
            end
            SEQ_BUSY: begin
               if (bcnt_q == '0) begin
                  state_q <= SEQ_IDLE;
                  row_q   <= row_next;
               end else begin
                  bcnt_q <= bcnt_q - 1'b1;
               end
            end
            default: state_q <= SEQ_IDLE;
         endcase
      end
   end

   assign busy = (state_q == SEQ_BUSY);
   assign row  = row_q;

endmodule

// File: rtl/refresh_scheduler.sv
module refresh_scheduler
   import refresh_pkg::*;
#(
   parameter int unsigned ROWS        = 8192,
   parameter int unsigned CLK_KHZ     = 133000,
   parameter int unsigned PERIOD_US   = 64000,
   parameter int unsigned BUSY_CYCLES = 4,
   parameter int unsigned PEND_MAX    = 8,
   localparam int unsigned ROW_W      = $clog2(ROWS),
   localparam int unsigned INTERVAL   = refresh_interval(CLK_KHZ, PERIOD_US, ROWS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ref_grant,
   output logic             ref_req,
   output logic [ROW_W-1:0] ref_row,
   output logic             ref_busy
);
   generate
      if (ROWS < 2) begin : g_bad_rows
         $error("refresh_scheduler: ROWS must be at least 2");
      end
      if (BUSY_CYCLES < 1) begin : g_bad_busy
         $error("refresh_scheduler: BUSY_CYCLES must be at least 1");
      end
      if (PEND_MAX < 1) begin : g_bad_pend
         $error("refresh_scheduler: PEND_MAX must be at least 1");
      end
      if (INTERVAL < BUSY_CYCLES + 2) begin : g_bad_interval
         $error("refresh_scheduler: interval too short for the busy window");
      end
   endgenerate

   logic tick;
   logic owed;
   logic take;
   logic busy;

   refresh_tick_gen #(
      .INTERVAL (INTERVAL)
   ) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick)
   );

   refresh_pend_ctr #(
      .PEND_MAX (PEND_MAX)
   ) u_pend (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick),
      .take  (take),
      .owed  (owed)
   );

   refresh_row_seq #(
      .ROWS        (ROWS),
      .BUSY_CYCLES (BUSY_CYCLES)
   ) u_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .start (take),
      .busy  (busy),
      .row   (ref_row)
   );

   assign ref_req  = owed & ~busy;
   assign take     = ref_req & ref_grant;
   assign ref_busy = busy;

endmodule

// File: rtl/refresh_scheduler_chk.sv
module refresh_scheduler_chk #(
   parameter int unsigned ROWS        = 8192,
   parameter int unsigned BUSY_CYCLES = 4,
   localparam int unsigned ROW_W      = $clog2(ROWS)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ref_grant,
   input logic             ref_req,
   input logic             ref_busy,
   input logic [ROW_W-1:0] ref_row
);
   localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);

   logic [15:0] blen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        blen_q <= '0;
      else if (ref_busy) blen_q <= blen_q + 1'b1;
      else               blen_q <= '0;
   end

   assert_req_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_req && !ref_grant) |=> (ref_req && $stable(ref_row)));

   assert_req_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_req && ref_grant) |=> (!ref_req && ref_busy));

   assert_busy_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ref_busy) |-> (blen_q == 16'(BUSY_CYCLES)));

   assert_row_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_busy && $past(ref_busy)) |-> $stable(ref_row));

   assert_row_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(ref_busy) && ($past(ref_row) != ROW_LAST)) |-> (ref_row == $past(ref_row) + 1'b1));

   assert_row_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(ref_busy) && ($past(ref_row) == ROW_LAST)) |-> (ref_row == '0));

   assert_no_req_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ref_busy |-> !ref_req);

   assert_stray_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!ref_req && !ref_busy && ref_grant) |=> (!ref_busy && $stable(ref_row)));

endmodule

bind refresh_scheduler refresh_scheduler_chk #(
   .ROWS        (ROWS),
   .BUSY_CYCLES (BUSY_CYCLES)
) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ref_grant (ref_grant),
   .ref_req   (ref_req),
   .ref_busy  (ref_busy),
   .ref_row   (ref_row)
);

// File: tb/test_refresh_scheduler.sv
`timescale 1ns/1ps
module test_refresh_scheduler;
   localparam int unsigned ROWS     = 16;
   localparam int unsigned CLK_KHZ  = 1000;
   localparam int unsigned PERIOD   = 1600;
   localparam int unsigned BUSY     = 4;
   localparam int unsigned PMAX     = 8;
   localparam int unsigned IVL      = 100;  // 1000*1600/1000/16
   localparam int unsigned ROW_W    = 4;

   logic             clk = 1'b0;
   logic             rst_n;
   logic             ref_grant;
   logic             ref_req;
   logic [ROW_W-1:0] ref_row;
   logic             ref_busy;

   int   checks = 0;
   int   fails  = 0;
   int   cyc    = 0;
   int   exp_row = 0;
   int   exp_q[$];
   bit   done   = 1'b0;

   always #2.5 clk = ~clk;

   refresh_scheduler #(
      .ROWS        (ROWS),
      .CLK_KHZ     (CLK_KHZ),
      .PERIOD_US   (PERIOD),
      .BUSY_CYCLES (BUSY),
      .PEND_MAX    (PMAX)
   ) i_refresh_scheduler (
      .clk       (clk),
      .rst_n     (rst_n),
      .ref_grant (ref_grant),
      .ref_req   (ref_req),
      .ref_row   (ref_row),
      .ref_busy  (ref_busy)
   );

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) cyc <= 0;
      else        cyc <= cyc + 1;
   end

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic report();
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
   endtask

   task automatic step();
      @(negedge clk);
      #1;
   endtask

   task automatic wait_req();
      while (!ref_req) step();
   endtask

   task automatic push_row();
      exp_q.push_back(exp_row);
      exp_row = (exp_row + 1) % ROWS;
   endtask

   task automatic grant_one();
      push_row();
      ref_grant = 1'b1;
      step();
      ref_grant = 1'b0;
   endtask

   // Monitor: pops the expected row for each accepted refresh, times busy.
   bit          prev_req  = 1'b0;
   bit          prev_busy = 1'b0;
   int          prev_row  = 0;
   int          run       = 0;
   always @(negedge clk) begin
      if (!rst_n) begin
         prev_req = 1'b0; prev_busy = 1'b0; run = 0;
      end else begin
         if (prev_req && ref_grant) begin
            chk(ref_busy && !ref_req, "R4 grant clears req, sets busy",
                {ref_busy, ref_req}, 2'b10);
            if (exp_q.size() == 0) begin
               chk(1'b0, "R8 refresh beyond owed count", prev_row, -1);
            end else begin
               int e;
               e = exp_q.pop_front();
               chk(prev_row == e, "R5/R6 refreshed row order", prev_row, e);
            end
         end
         if (ref_busy) run++;
         else if (prev_busy) begin
            chk(run == BUSY, "R4 busy length", run, BUSY);
            run = 0;
         end
         prev_req  = ref_req;
         prev_busy = ref_busy;
         prev_row  = int'(ref_row);
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
         report();
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0;
      ref_grant = 1'b0;
      repeat (3) step();
      chk(ref_req == 1'b0,  "R1 req in reset",  ref_req, 0);
      chk(ref_busy == 1'b0, "R1 busy in reset", ref_busy, 0);
      chk(ref_row == '0,    "R1 row in reset",  ref_row, 0);
      rst_n = 1'b1;
      step();
      chk(ref_req == 1'b0 && ref_busy == 1'b0, "R1 idle after release", ref_req, 0);

      // R2: first request and regular spacing
      wait_req();
      chk(cyc == IVL, "R2 first request", cyc, IVL);
      grant_one();
      for (int k = 2; k <= 4; k++) begin
         wait_req();
         chk(cyc == k * IVL, "R2 request spacing", cyc, k * IVL);
         grant_one();
      end

      // R9: grant without request is ignored
      while (ref_busy) step();
      ref_grant = 1'b1;
      for (int i = 0; i < 20; i++) begin
         step();
         if (i % 5 == 4) chk(ref_busy == 1'b0, "R9 stray grant busy", ref_busy, 0);
      end
      ref_grant = 1'b0;
      chk(int'(ref_row) == exp_row, "R9 stray grant row", ref_row, exp_row);

      // R3: request held until granted
      wait_req();
      for (int i = 0; i < 7; i++) step();
      chk(ref_req == 1'b1, "R3 request held", ref_req, 1);
      chk(int'(ref_row) == exp_row, "R3 row held", ref_row, exp_row);
      grant_one();

      // R6: run past the last row
      for (int i = 0; i < 13; i++) begin
         wait_req();
         grant_one();
      end
      while (ref_busy) step();
      chk(int'(ref_row) == exp_row, "R6 row after wrap", ref_row, exp_row);

      // R7: three owed refreshes served back to back
      wait_req();
      repeat (2 * IVL) step();
      repeat (3) push_row();
      ref_grant = 1'b1;
      repeat (16) step();
      ref_grant = 1'b0;
      chk(exp_q.size() == 0, "R7 backlog drained", exp_q.size(), 0);
      chk(ref_req == 1'b0 && ref_busy == 1'b0, "R7 idle after backlog", ref_req, 0);

      // R8: owed count saturates
      wait_req();
      repeat (10 * IVL) step();
      repeat (PMAX) push_row();
      ref_grant = 1'b1;
      repeat (60) step();
      ref_grant = 1'b0;
      chk(exp_q.size() == 0, "R8 saturated backlog served", exp_q.size(), 0);
      chk(ref_req == 1'b0, "R8 no extra request", ref_req, 0);
      chk(int'(ref_row) == exp_row, "R5 row after drain", ref_row, exp_row);

      done = 1'b1;
      report();
      $finish;
   end

endmodule